// File: doc/BRIEF.md
# Full-Bridge Fault and Soft-Start Sequencer

This block decides when the four switches of a phase-shifted full bridge may be driven, and by how much. It watches a set of event flags that comparators outside the block have already reduced to single bits. These flags report supply level, reference health, an external disable request, two current thresholds and two error-signal levels. From them it runs a five-state sequence: off, soft-start, run, soft-stop and light-load idle.

While it does so it keeps a digital soft-start word. On every ramp tick this word rises by a programmable step during soft-start. During soft-stop it falls ten times as fast. It is forced to zero whenever a hard fault is present. The duty or phase command from the loop is limited to this word before it reaches the modulator.

An overcurrent does not latch the bridge off. Instead the outputs drop at once, the word ramps down to a floor, and a full soft-start follows. A lower current threshold only cuts the present pulse short. Supply monitoring and light-load detection each keep their own hysteresis flag, so that a signal sitting between its two thresholds changes nothing.

Top module: `fault_seq_ctrl`

## Requirements
- R1: After reset the state is off (code 0), the soft-start word is 0, and `out_en` and `pulse_out` are 0.
- R2: The supply flag is set one edge after `vdd_on_ok` is high and cleared one edge after `vdd_run_ok` is low; with `vdd_on_ok` low and `vdd_run_ok` high it keeps its value, so the block neither starts from off nor stops once started.
- R3: A hard fault (supply flag clear, `ref_good` low or `dis_req` high) drops `out_en` in the same cycle and moves the state to off with the word at 0 on the next edge.
- R4: In off with no hard fault, the next edge enters soft-start; in soft-start each edge with `tick` high adds `step_inc` to the word, saturating at full scale (all ones), and edges with `tick` low hold it.
- R5: Soft-start moves to run on the edge after the word has reached full scale; in run the word stays at full scale.
- R6: `oc_trip` high forces `out_en` and `pulse_out` low in the same cycle, and from soft-start, run or idle (with no hard fault) the next edge enters soft-stop.
- R7: In soft-stop each ticked edge lowers the word by 10 times `step_inc`, floored at 0; on the edge after the word is below `DIS_LVL` (default 32) the state becomes soft-start.
- R8: The load flag is set one edge after `err_hi` is high and cleared one edge after `err_lo` is low, and is held otherwise. Run moves to idle on the edge after the flag is clear, and idle moves back to run on the edge after it is set. `out_en` is 0 in idle.
- R9: `duty_lim` equals the smaller of `duty_cmd` and the soft-start word at all times.
- R10: `pulse_out` follows `pwm_req` while `out_en` is high; `pk_trip` ends the pulse at once and keeps it low until `pwm_req` falls, without changing the state.
- R11: `state_o` codes are 0 off, 1 soft-start, 2 run, 3 soft-stop, 4 idle; no other code appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Ramp step enable |
| vdd_on_ok | input | 1 | Supply above start-up level |
| vdd_run_ok | input | 1 | Supply above minimum operating level |
| ref_good | input | 1 | Reference voltage in range |
| dis_req | input | 1 | External disable request |
| oc_trip | input | 1 | Overcurrent (upper current threshold) |
| pk_trip | input | 1 | Peak current limit (lower threshold) |
| err_hi | input | 1 | Error signal above upper idle level |
| err_lo | input | 1 | Error signal above lower idle level |
| pwm_req | input | 1 | Raw pulse request from the modulator |
| duty_cmd | input | RAMP_W | Duty or phase command |
| step_inc | input | INC_W | Soft-start increment per tick |
| out_en | output | 1 | Bridge output enable |
| pulse_out | output | 1 | Gated pulse to the bridge |
| duty_lim | output | RAMP_W | Command clamped to the soft-start word |
| ramp_val | output | RAMP_W | Soft-start word |
| state_o | output | 3 | Sequencer state code |

## Verification
Enables and pulse gating react in the same cycle as `oc_trip`, `dis_req`, `ref_good` or `pk_trip`. So the bench changes these inputs, waits one time step and reads the outputs before any edge. State and word moves driven by `dis_req`, `ref_good`, `oc_trip` and `tick` are due after one edge. Moves that go through the supply or load hysteresis flag take two edges: one to update the flag and one for the state. Every vector in the table carries the number of edges to wait, and the bench samples at the falling edge after the last of them.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  typedef enum logic [2:0] {
    SS_OFF  = 3'd0,
    SS_RISE = 3'd1,
    SS_RUN  = 3'd2,
    SS_FALL = 3'd3,
    SS_IDLE = 3'd4
  } ss_state_e;
endpackage

// File: rtl/ssc_hyst_flag.sv
// Two-threshold flag: set by the upper comparator, cleared when the lower one drops.
module ssc_hyst_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic keep_i,
  output logic flag_o
);
  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (set_i)       flag_d = 1'b1;
    else if (!keep_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end
endmodule

// File: rtl/ssc_ramp.sv
// Soft-start word: rises by inc per tick, falls by MULT*inc per tick, clears on demand.
module ssc_ramp #(
  parameter int W     = 10,
  parameter int INC_W = 8,
  parameter int MULT  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic             tick_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     val_o
);
  localparam int MW    = $clog2(MULT + 1);
  localparam int DEC_W = INC_W + MW;
  localparam int SUM_W = ((W > DEC_W) ? W : DEC_W) + 1;
  localparam logic [W-1:0] FULL = '1;

  logic [DEC_W-1:0] dec;
  logic [SUM_W-1:0] v_ext, up_sum, dec_ext, diff;
  logic [W-1:0]     val_d;
  logic             val_en;

  always_comb begin
    dec     = DEC_W'(inc_i) * DEC_W'(MULT);
    v_ext   = SUM_W'(val_o);
    up_sum  = v_ext + SUM_W'(inc_i);
    dec_ext = SUM_W'(dec);
    diff    = v_ext - dec_ext;
    val_en  = clr_i | (tick_i & (up_i | dn_i));
    val_d   = val_o;
    if (clr_i)
      val_d = '0;
    else if (up_i)
      val_d = (up_sum > SUM_W'(FULL)) ? FULL : up_sum[W-1:0];
    else if (dn_i)
      val_d = (v_ext <= dec_ext) ? '0 : diff[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_o <= '0;
    else if (val_en) val_o <= val_d;
  end
endmodule

// File: rtl/ssc_pulse_gate.sv
// Cycle-by-cycle limit: a peak trip ends the pulse until the request falls.
module ssc_pulse_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic req_i,
  input  logic lim_i,
  output logic pulse_o
);
  logic term_q, term_d;

  always_comb begin
    term_d = term_q;
    if (!req_i)     term_d = 1'b0;
    else if (lim_i) term_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) term_q <= 1'b0;
    else        term_q <= term_d;
  end

  assign pulse_o = en_i & req_i & ~lim_i & ~term_q;
endmodule

// File: rtl/fault_seq_ctrl.sv
module fault_seq_ctrl #(
  parameter int RAMP_W    = 10,
  parameter int INC_W     = 8,
  parameter int STOP_MULT = 10,
  parameter int DIS_LVL   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              vdd_on_ok,
  input  logic              vdd_run_ok,
  input  logic              ref_good,
  input  logic              dis_req,
  input  logic              oc_trip,
  input  logic              pk_trip,
  input  logic              err_hi,
  input  logic              err_lo,
  input  logic              pwm_req,
  input  logic [RAMP_W-1:0] duty_cmd,
  input  logic [INC_W-1:0]  step_inc,
  output logic              out_en,
  output logic              pulse_out,
  output logic [RAMP_W-1:0] duty_lim,
  output logic [RAMP_W-1:0] ramp_val,
  output logic [2:0]        state_o
);
  import ssc_pkg::*;

  localparam int NFLAG = 2;
  localparam logic [RAMP_W-1:0] FULL    = '1;
  localparam logic [RAMP_W-1:0] DIS_CMP = RAMP_W'(DIS_LVL);

  // flag 0: supply good, flag 1: load present
  logic [NFLAG-1:0] h_set, h_keep, h_flag;
  logic supply_ok, load_ok, hard_fault;
  ss_state_e st_q, st_d;

  assign h_set  = {err_hi, vdd_on_ok};
  assign h_keep = {err_lo, vdd_run_ok};

  for (genvar g = 0; g < NFLAG; g++) begin : g_hyst
    ssc_hyst_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (h_set[g]),
      .keep_i (h_keep[g]),
      .flag_o (h_flag[g])
    );
  end

  assign supply_ok  = h_flag[0];
  assign load_ok    = h_flag[1];
  assign hard_fault = ~supply_ok | ~ref_good | dis_req;

  always_comb begin
    st_d = st_q;
    if (hard_fault) st_d = SS_OFF;
    else begin
      unique case (st_q)
        SS_OFF:  st_d = SS_RISE;
        SS_RISE: if (oc_trip) st_d = SS_FALL;
                 else if (ramp_val == FULL) st_d = SS_RUN;
        SS_RUN:  if (oc_trip) st_d = SS_FALL;
                 else if (!load_ok) st_d = SS_IDLE;
        SS_IDLE: if (oc_trip) st_d = SS_FALL;
                 else if (load_ok) st_d = SS_RUN;
        SS_FALL: if (ramp_val < DIS_CMP) st_d = SS_RISE;
        default: st_d = SS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SS_OFF;
    else        st_q <= st_d;
  end

  ssc_ramp #(.W(RAMP_W), .INC_W(INC_W), .MULT(STOP_MULT)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (hard_fault | (st_q == SS_OFF)),
    .up_i   (st_q == SS_RISE),
    .dn_i   (st_q == SS_FALL),
    .tick_i (tick),
    .inc_i  (step_inc),
    .val_o  (ramp_val)
  );

  assign out_en = ((st_q == SS_RISE) | (st_q == SS_RUN)) & ~oc_trip & ~hard_fault;

  ssc_pulse_gate u_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (out_en),
    .req_i   (pwm_req),
    .lim_i   (pk_trip),
    .pulse_o (pulse_out)
  );

  assign duty_lim = (duty_cmd < ramp_val) ? duty_cmd : ramp_val;
  assign state_o  = st_q;
endmodule

// File: rtl/ssc_chk.sv
module ssc_chk #(
  parameter int RAMP_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        state_o,
  input logic [RAMP_W-1:0] ramp_val,
  input logic              out_en,
  input logic              pulse_out,
  input logic              oc_trip,
  input logic              pk_trip,
  input logic              dis_req,
  input logic              ref_good,
  input logic              supply_ok,
  input logic [RAMP_W-1:0] duty_cmd,
  input logic [RAMP_W-1:0] duty_lim
);
  localparam logic [RAMP_W-1:0] FULL = '1;

  assert_off_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0) |-> (ramp_val == '0));
  assert_disable_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dis_req |=> (state_o == 3'd0));
  assert_oc_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oc_trip |-> (!out_en && !pulse_out));
  assert_oc_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && supply_ok && ref_good && !dis_req &&
     (state_o == 3'd1 || state_o == 3'd2 || state_o == 3'd4)) |=> (state_o == 3'd3));
  assert_run_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd2) |-> (ramp_val == FULL));
  assert_idle_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd4) |-> !out_en);
  assert_clamp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_lim <= ramp_val) && (duty_lim <= duty_cmd));
  assert_peak_cut_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pk_trip |-> !pulse_out);
  assert_state_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    state_o <= 3'd4);
endmodule

bind fault_seq_ctrl ssc_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .state_o   (state_o),
  .ramp_val  (ramp_val),
  .out_en    (out_en),
  .pulse_out (pulse_out),
  .oc_trip   (oc_trip),
  .pk_trip   (pk_trip),
  .dis_req   (dis_req),
  .ref_good  (ref_good),
  .supply_ok (supply_ok),
  .duty_cmd  (duty_cmd),
  .duty_lim  (duty_lim)
);

// File: tb/fault_seq_ctrl_bench.sv
module fault_seq_ctrl_bench;
  localparam int RW = 10;
  localparam int IW = 8;
  localparam int NV = 24;
  // {vdd_on,vdd_run,ref,dis,oc,err_hi,err_lo,tick}[39:32] cycles[31:24] state[23:21] ramp[20:11] en[10]
  localparam logic [39:0] VEC [0:NV-1] = '{
    {8'b01100111, 8'd3,  3'd0, 10'd0,    1'b0, 10'd0}, // R2 no start
    {8'b11100111, 8'd1,  3'd0, 10'd0,    1'b0, 10'd0}, // R2 flag only
    {8'b11100111, 8'd1,  3'd1, 10'd0,    1'b1, 10'd0}, // R4 enter rise
    {8'b01100111, 8'd3,  3'd1, 10'd192,  1'b1, 10'd0}, // R2 R4
    {8'b01100111, 8'd12, 3'd1, 10'd960,  1'b1, 10'd0}, // R4
    {8'b01100111, 8'd1,  3'd1, 10'd1023, 1'b1, 10'd0}, // R4 saturate
    {8'b01100111, 8'd1,  3'd2, 10'd1023, 1'b1, 10'd0}, // R5
    {8'b01100011, 8'd3,  3'd2, 10'd1023, 1'b1, 10'd0}, // R8 between levels
    {8'b01100001, 8'd2,  3'd4, 10'd1023, 1'b0, 10'd0}, // R8 idle
    {8'b01100011, 8'd2,  3'd4, 10'd1023, 1'b0, 10'd0}, // R8 hold idle
    {8'b01100111, 8'd2,  3'd2, 10'd1023, 1'b1, 10'd0}, // R8 back to run
    {8'b01101111, 8'd1,  3'd3, 10'd1023, 1'b0, 10'd0}, // R6
    {8'b01100111, 8'd1,  3'd3, 10'd383,  1'b0, 10'd0}, // R7
    {8'b01100111, 8'd1,  3'd3, 10'd0,    1'b0, 10'd0}, // R7 floor
    {8'b01100111, 8'd1,  3'd1, 10'd0,    1'b1, 10'd0}, // R7 restart
    {8'b01100111, 8'd2,  3'd1, 10'd128,  1'b1, 10'd0}, // R4
    {8'b01110111, 8'd1,  3'd0, 10'd0,    1'b0, 10'd0}, // R3 disable
    {8'b01100111, 8'd1,  3'd1, 10'd0,    1'b1, 10'd0}, // R4
    {8'b01100111, 8'd2,  3'd1, 10'd128,  1'b1, 10'd0}, // R4
    {8'b01000111, 8'd1,  3'd0, 10'd0,    1'b0, 10'd0}, // R3 reference
    {8'b01100111, 8'd3,  3'd1, 10'd128,  1'b1, 10'd0}, // R4
    {8'b00100111, 8'd1,  3'd1, 10'd192,  1'b0, 10'd0}, // R2 R3 flag drops
    {8'b00100111, 8'd1,  3'd0, 10'd0,    1'b0, 10'd0}, // R3 supply
    {8'b01100111, 8'd3,  3'd0, 10'd0,    1'b0, 10'd0}  // R2 no restart
  };

  logic clk = 1'b0;
  logic rst_n;
  logic tick, vdd_on_ok, vdd_run_ok, ref_good, dis_req, oc_trip, pk_trip;
  logic err_hi, err_lo, pwm_req;
  logic [RW-1:0] duty_cmd;
  logic [IW-1:0] step_inc;
  logic out_en, pulse_out;
  logic [RW-1:0] duty_lim, ramp_val;
  logic [2:0] state_o;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  fault_seq_ctrl u_fault_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vdd_on_ok(vdd_on_ok),
    .vdd_run_ok(vdd_run_ok), .ref_good(ref_good), .dis_req(dis_req),
    .oc_trip(oc_trip), .pk_trip(pk_trip), .err_hi(err_hi), .err_lo(err_lo),
    .pwm_req(pwm_req), .duty_cmd(duty_cmd), .step_inc(step_inc),
    .out_en(out_en), .pulse_out(pulse_out), .duty_lim(duty_lim),
    .ramp_val(ramp_val), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {vdd_on_ok, vdd_run_ok, ref_good, dis_req, oc_trip, err_hi, err_lo, tick} = '0;
    pk_trip = 1'b0; pwm_req = 1'b0;
    duty_cmd = 10'd300; step_inc = 8'd64;
    step(3);
    chk("R1 state", int'(state_o), 0);
    chk("R1 ramp", int'(ramp_val), 0);
    chk("R1 out_en", int'(out_en), 0);
    chk("R1 pulse", int'(pulse_out), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {vdd_on_ok, vdd_run_ok, ref_good, dis_req, oc_trip, err_hi, err_lo, tick} = VEC[i][39:32];
      step(int'(VEC[i][31:24]));
      chk($sformatf("R11 vec%0d state", i), int'(state_o), int'(VEC[i][23:21]));
      chk($sformatf("R4 vec%0d ramp", i), int'(ramp_val), int'(VEC[i][20:11]));
      chk($sformatf("R3 vec%0d out_en", i), int'(out_en), int'(VEC[i][10]));
    end

    // directed: tick gating, clamp, pulse limit, overcurrent gating
    vdd_on_ok = 1'b1;
    step(2);
    vdd_on_ok = 1'b0;
    chk("R4 rise again", int'(state_o), 1);
    tick = 1'b0;
    step(3);
    chk("R4 tick low holds", int'(ramp_val), 0);
    duty_cmd = 10'd500; #1;
    chk("R9 clamp at zero", int'(duty_lim), 0);
    tick = 1'b1;
    step(2);
    duty_cmd = 10'd500; #1;
    chk("R9 clamp to word", int'(duty_lim), 128);
    duty_cmd = 10'd50; #1;
    chk("R9 command below word", int'(duty_lim), 50);
    for (int k = 0; k < 40 && state_o != 3'd2; k++) step(1);
    chk("R5 reach run", int'(state_o), 2);
    chk("R5 full scale", int'(ramp_val), 1023);
    pwm_req = 1'b1; #1;
    chk("R10 pulse follows", int'(pulse_out), 1);
    pk_trip = 1'b1; #1;
    chk("R10 peak cut", int'(pulse_out), 0);
    step(1);
    pk_trip = 1'b0; #1;
    chk("R10 stays cut", int'(pulse_out), 0);
    chk("R10 state kept", int'(state_o), 2);
    pwm_req = 1'b0;
    step(1);
    pwm_req = 1'b1; #1;
    chk("R10 next pulse", int'(pulse_out), 1);
    oc_trip = 1'b1; #1;
    chk("R6 en drops now", int'(out_en), 0);
    chk("R6 pulse drops now", int'(pulse_out), 0);
    tick = 1'b0;
    step(1);
    oc_trip = 1'b0;
    chk("R6 soft-stop", int'(state_o), 3);
    step(2);
    chk("R7 untimed hold", int'(ramp_val), 1023);
    chk("R7 still stopping", int'(state_o), 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule